// File: doc/BRIEF.md
# Scanned Seven-Segment Display Driver

This block drives a multi-digit seven-segment display one position at a time, so only seven segment lines plus one enable per position leave the chip instead of seven lines per digit. It keeps a small scan index, drives that index out as `digit_select`, and expects the neighbouring time-keeping block to answer combinationally with the 4-bit BCD digit stored at that position. The returned digit is decoded straight to segment lines, with no binary-to-decimal step, and a one-hot enable lights the matching position.

The scan rate comes from a free-running clock enable `tick_en`. Every `TICKS_PER_SLOT` ticks the driver moves to the next slot. Each slot starts with one dark cycle in which the index moves and all enables and segments are off. The next cycle captures and shows the returned digit, which then holds until the next slot begins. The digit fetch is a plain combinational lookup with no handshake. The neighbour only has to hold `digit_in` valid for the current `digit_select` in the cycle after the index moves. The driver holds the captured digit from then on. `TICKS_PER_SLOT` must be at least 2.

Top module: `seg_scan_driver`

## Requirements
- R1: While `rst_n` is low, `digit_select`, `enable` and `segments` are all zero, and the tick prescaler restarts its count.
- R2: A scan step happens on the clock edge that samples the `TICKS_PER_SLOT`-th high `tick_en` since the previous step or reset (default 4). Cycles with `tick_en` low are not counted and change nothing.
- R3: The first scan step after reset keeps `digit_select` at 0. Each later step advances it by one, and it wraps from `DIGITS-1` to 0, giving the order 0,1,2,3,0,...
- R4: On the edge of a scan step, `enable` and `segments` go to all zero for exactly one cycle. On the following edge `enable` turns on the position given by `digit_select`.
- R5: `enable` is either all zero or has exactly the single bit `1 << digit_select` set.
- R6: `digit_select` changes only in a cycle where `enable` is zero, so it is settled one cycle before its position is lit.
- R7: Segments are active high, with segment a on bit 0 through segment g on bit 6. BCD 0..9 give hex 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R8: BCD codes 10 to 15 give all segments off (hex 00) while the position is enabled.
- R9: `segments` shows the `digit_in` value sampled on the edge where the position is lit, and holds it for the rest of the slot even if `digit_in` changes.
- R10: Once lit, `enable` stays unchanged until the next scan step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Scan-rate clock enable, one cycle per tick |
| digit_in | input | 4 | BCD digit returned for the current `digit_select` |
| digit_select | output | $clog2(DIGITS) | Scan index presented to the digit source |
| enable | output | DIGITS | One-hot position enable, active high |
| segments | output | 7 | Segment lines a..g on bits 0..6, active high |

## Verification
The bench goes after the first step, which must keep index 0 where a careless design skips position 0 until the first wrap. It also checks the wrap from 3 back to 0, and partial tick counts split by idle cycles; a prescaler that counts clocks instead of ticks would step early. A `digit_in` that changes mid-slot catches a design that decodes live instead of capturing, because its segments would follow the input. Codes 10 to 15 and a reset in the middle of a tick count show up a decoder that wraps the codes or a prescaler that keeps a stale count, which would step after too few ticks.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [BCD_W-1:0] bcd_t;

  // Segment bit positions, active high.
  localparam int SEG_A = 0;
  localparam int SEG_B = 1;
  localparam int SEG_C = 2;
  localparam int SEG_D = 3;
  localparam int SEG_E = 4;
  localparam int SEG_F = 5;
  localparam int SEG_G = 6;

  localparam seg_t SEG_DARK = '0;

  // Build a segment word from individual lit flags.
  function automatic seg_t seg_word(input bit a, input bit b, input bit c,
                                    input bit d, input bit e, input bit f,
                                    input bit g);
    seg_t w;
    w = SEG_DARK;
    w[SEG_A] = a;
    w[SEG_B] = b;
    w[SEG_C] = c;
    w[SEG_D] = d;
    w[SEG_E] = e;
    w[SEG_F] = f;
    w[SEG_G] = g;
    return w;
  endfunction

endpackage

// File: rtl/seg_prescale.sv
module seg_prescale #(
  parameter int TICKS_PER_SLOT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic step
);

  localparam int CNT_W = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SLOT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign step    = tick_en && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      if (at_last) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/seg_scan_seq.sv
module seg_scan_seq #(
  parameter int DIGITS = 4,
  localparam int SEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [SEL_W-1:0] sel,
  output logic             blank,
  output logic             show
);

  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(DIGITS - 1);

  logic [SEL_W-1:0] sel_q;
  logic             started_q;
  logic             show_q;
  logic [SEL_W-1:0] sel_next;

  always_comb begin
    if (!started_q) begin
      sel_next = '0;
    end else if (sel_q == SEL_LAST) begin
      sel_next = '0;
    end else begin
      sel_next = sel_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      started_q <= 1'b0;
      show_q    <= 1'b0;
    end else begin
      show_q <= step;
      if (step) begin
        sel_q     <= sel_next;
        started_q <= 1'b1;
      end
    end
  end

  assign sel   = sel_q;
  assign blank = step;
  assign show  = show_q;

endmodule

// File: rtl/seg_bcd_decode.sv
module seg_bcd_decode
  import seg_scan_pkg::*;
(
  input  bcd_t digit,
  output seg_t seg
);

  always_comb begin
    unique case (digit)
      4'd0:    seg = seg_word(1, 1, 1, 1, 1, 1, 0);
      4'd1:    seg = seg_word(0, 1, 1, 0, 0, 0, 0);
      4'd2:    seg = seg_word(1, 1, 0, 1, 1, 0, 1);
      4'd3:    seg = seg_word(1, 1, 1, 1, 0, 0, 1);
      4'd4:    seg = seg_word(0, 1, 1, 0, 0, 1, 1);
      4'd5:    seg = seg_word(1, 0, 1, 1, 0, 1, 1);
      4'd6:    seg = seg_word(1, 0, 1, 1, 1, 1, 1);
      4'd7:    seg = seg_word(1, 1, 1, 0, 0, 0, 0);
      4'd8:    seg = seg_word(1, 1, 1, 1, 1, 1, 1);
      4'd9:    seg = seg_word(1, 1, 1, 1, 0, 1, 1);
      default: seg = SEG_DARK;
    endcase
  end

endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_scan_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int SEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank,
  input  logic              show,
  input  logic [SEL_W-1:0]  sel,
  input  seg_t              seg_in,
  output logic [DIGITS-1:0] enable,
  output seg_t              segments
);

  logic [DIGITS-1:0] pos_hot;
  logic [DIGITS-1:0] en_q;
  seg_t              seg_q;

  for (genvar i = 0; i < DIGITS; i++) begin : g_pos
    assign pos_hot[i] = (sel == SEL_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      seg_q <= SEG_DARK;
    end else if (blank) begin
      en_q  <= '0;
      seg_q <= SEG_DARK;
    end else if (show) begin
      en_q  <= pos_hot;
      seg_q <= seg_in;
    end
  end

  assign enable   = en_q;
  assign segments = seg_q;

endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver
  import seg_scan_pkg::*;
#(
  parameter int DIGITS         = 4,
  parameter int TICKS_PER_SLOT = 4,
  localparam int SEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [3:0]        digit_in,
  output logic [SEL_W-1:0]  digit_select,
  output logic [DIGITS-1:0] enable,
  output logic [6:0]        segments
);

  logic             step;
  logic             blank;
  logic             show;
  logic [SEL_W-1:0] sel;
  seg_t             seg_dec;
  seg_t             seg_out;

  seg_prescale #(
    .TICKS_PER_SLOT(TICKS_PER_SLOT)
  ) u_prescale (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .step   (step)
  );

  seg_scan_seq #(
    .DIGITS(DIGITS)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .step (step),
    .sel  (sel),
    .blank(blank),
    .show (show)
  );

  seg_bcd_decode u_dec (
    .digit(bcd_t'(digit_in)),
    .seg  (seg_dec)
  );

  seg_out_stage #(
    .DIGITS(DIGITS)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .blank   (blank),
    .show    (show),
    .sel     (sel),
    .seg_in  (seg_dec),
    .enable  (enable),
    .segments(seg_out)
  );

  assign digit_select = sel;
  assign segments     = seg_out;

endmodule

// File: rtl/seg_scan_driver_chk.sv
module seg_scan_driver_chk #(
  parameter int DIGITS = 4,
  localparam int SEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        digit_in,
  input logic [SEL_W-1:0]  digit_select,
  input logic [DIGITS-1:0] enable,
  input logic [6:0]        segments
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (enable == '0 && segments == '0 && digit_select == '0));

  // R5
  onehot_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable != '0) |-> (enable == (DIGITS'(1) << digit_select)));

  // R6
  sel_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(digit_select) |-> (enable == '0));

  // R4
  dark_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> (segments == '0));

  // R9
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable != '0 && $past(enable) != '0) |-> ($stable(segments) && $stable(enable)));

  // R8
  nondecimal_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) == '0 && enable != '0 && $past(digit_in) > 4'd9) |-> (segments == '0));

endmodule

bind seg_scan_driver seg_scan_driver_chk #(.DIGITS(DIGITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .digit_in    (digit_in),
  .digit_select(digit_select),
  .enable      (enable),
  .segments    (segments)
);

// File: tb/seg_scan_driver_test.sv
module seg_scan_driver_test;

  localparam int DIGITS = 4;
  localparam int TPS    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] digit_in;
  logic [1:0] digit_select;
  logic [3:0] enable;
  logic [6:0] segments;

  logic [3:0] digits [0:DIGITS-1];

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;
  int  exp_sel = 0;
  bit  started = 1'b0;

  always #4 clk = ~clk;

  assign digit_in = digits[digit_select];

  seg_scan_driver #(.DIGITS(DIGITS), .TICKS_PER_SLOT(TPS)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .digit_in    (digit_in),
    .digit_select(digit_select),
    .enable      (enable),
    .segments    (segments)
  );

  function automatic logic [6:0] ref_seg(input logic [3:0] code);
    case (code)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_digits(input logic [3:0] d0, input logic [3:0] d1,
                            input logic [3:0] d2, input logic [3:0] d3);
    digits[0] = d0;
    digits[1] = d1;
    digits[2] = d2;
    digits[3] = d3;
  endtask

  // One full slot: TPS ticks, check the dark cycle, then the lit cycle.
  task automatic scan_step();
    logic [3:0] code;
    repeat (TPS) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
    if (started) exp_sel = (exp_sel + 1) % DIGITS;
    started = 1'b1;
    chk("R4", "dark enable", int'(enable), 0);
    chk("R4", "dark segments", int'(segments), 0);
    chk("R3", "digit_select", int'(digit_select), exp_sel);
    @(negedge clk);
    code = digits[exp_sel];
    chk("R5", "lit enable", int'(enable), 1 << exp_sel);
    chk(code > 9 ? "R8" : "R7", "lit segments", int'(segments), int'(ref_seg(code)));
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset enable", int'(enable), 0);
    chk("R1", "reset segments", int'(segments), 0);
    chk("R1", "reset digit_select", int'(digit_select), 0);
    rst_n   = 1'b1;
    started = 1'b0;
    exp_sel = 0;
    repeat (2) @(negedge clk);
    chk("R1", "enable off before first step", int'(enable), 0);
  endtask

  task automatic test_first_step();
    set_digits(4'd5, 4'd1, 4'd2, 4'd3);
    scan_step();
    chk("R3", "first step stays at 0", int'(digit_select), 0);
  endtask

  task automatic test_rotation();
    set_digits(4'd4, 4'd7, 4'd2, 4'd9);
    for (int k = 0; k < 5; k++) scan_step();
    chk("R3", "wrapped index", int'(digit_select), 1);
  endtask

  task automatic test_all_codes();
    for (int c = 0; c < 16; c++) begin
      set_digits(4'(c), 4'(c), 4'(c), 4'(c));
      scan_step();
    end
  endtask

  task automatic test_partial_ticks();
    logic [3:0] en_before;
    logic [1:0] sel_before;
    set_digits(4'd0, 4'd6, 4'd8, 4'd3);
    scan_step();
    en_before  = enable;
    sel_before = digit_select;
    repeat (TPS - 1) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2", "no step before last tick", int'(enable), int'(en_before));
    chk("R2", "index held across idle cycles", int'(digit_select), int'(sel_before));
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    exp_sel = (exp_sel + 1) % DIGITS;
    chk("R2", "step on last tick", int'(enable), 0);
    chk("R3", "index after split ticks", int'(digit_select), exp_sel);
    @(negedge clk);
    chk("R5", "lit after split ticks", int'(enable), 1 << exp_sel);
    chk("R7", "segments after split ticks", int'(segments), int'(ref_seg(digits[exp_sel])));
  endtask

  task automatic test_hold();
    logic [6:0] seg_before;
    logic [3:0] en_before;
    set_digits(4'd2, 4'd2, 4'd2, 4'd2);
    scan_step();
    seg_before = segments;
    en_before  = enable;
    set_digits(4'd8, 4'd8, 4'd8, 4'd8);
    repeat (6) @(negedge clk);
    chk("R9", "segments held after digit change", int'(segments), int'(seg_before));
    chk("R10", "enable held within slot", int'(enable), int'(en_before));
  endtask

  task automatic test_mid_reset();
    repeat (2) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
    do_reset();
    set_digits(4'd9, 4'd1, 4'd1, 4'd1);
    scan_step();
    chk("R1", "prescaler restarted by reset", int'(digit_select), 0);
  endtask

  initial begin
    set_digits(4'd0, 4'd0, 4'd0, 4'd0);
    do_reset();
    test_first_step();
    test_rotation();
    test_all_codes();
    test_partial_ticks();
    test_hold();
    test_mid_reset();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule